// File: doc/BRIEF.md
# Asynchronous SRAM-Style Bus Responder

This block is the device side of an asynchronous parallel memory bus, rebuilt as synchronous logic that runs on a fast sampling clock. It watches two chip enables of opposite polarity, a write strobe, an output enable, two byte selects, an address and a write-data bus. From these it decides when an access opens, whether it is a read or a write, when a write is stored, and when each byte lane of the read bus is driven. A small byte-lane array inside the block holds the data.

All bus inputs pass through two-flop synchronizers. The control logic then detects edges on the synchronized copies. Read latency, page latency and the precharge interval are parameters counted in sample-clock cycles. The word address is split into a row part and a column part. While the block stays selected, a change in the row part starts a new random access, and a change in the column part alone starts a faster page access. A supply-good input blocks every access while it is low. A one-cycle violation pulse marks two conditions: an access attempted during precharge, and write data that changed inside the setup window before the commit.

The controller is an enumerated state machine. Its states:
- ST_IDLE: no access.
- ST_READ: random access under way.
- ST_PAGE: column access under way.
- ST_RDY: read data valid.
- ST_WRITE: write open.
- ST_PRECH: precharge.

Its transitions:
- open: ST_IDLE to ST_READ or ST_WRITE, on the enable edge.
- strobe-low: ST_READ, ST_PAGE or ST_RDY to ST_WRITE.
- row-change: to ST_READ.
- column-change: ST_RDY to ST_PAGE.
- count-done: ST_READ or ST_PAGE to ST_RDY, or ST_PRECH to ST_IDLE.
- strobe-high commit: ST_WRITE to ST_RDY.
- deselect: any open state to ST_PRECH, committing first when leaving ST_WRITE.
- supply-drop: any state to ST_IDLE.

Top module: `sram_bus_responder`

## Requirements
- R1: After reset, bus_drv is 2'b00, bus_dout is zero and timing_viol is low.
- R2: An access opens when the block becomes selected, where selected means en_a_n low and en_b high. This happens either by en_a_n falling while en_b is high, or by en_b rising while en_a_n is low. The whole address is latched at that moment.
- R3: If wr_n is low when an access opens, the access is a write, and bus_drv stays 2'b00 for the whole of it whatever out_en_n does.
- R4: If wr_n falls during an open read access, the bus is released within three sample cycles. The access becomes a write to the column given by the low COL_W address bits at that fall, so a second strobe with a new column writes a second word of the same row.
- R5: Write data is stored at whichever comes first: wr_n rising, en_a_n rising or en_b falling. Only the lanes whose select is low are written: lo_sel_n guards bits 7:0 and hi_sel_n guards bits 15:8.
- R6: bus_drv[1] is high only when out_en_n and hi_sel_n are low and read data is valid, and bus_drv[0] is the same with lo_sel_n. An undriven lane of bus_dout reads zero.
- R7: When out_en_n is low before the read latency has elapsed, the bus stays undriven until data is valid (ACC_CYC cycles after the opening edge is seen).
- R8: While selected, a change in the row bits starts a new random access, during which the bus is released. A change only in the low COL_W bits returns the word at the new column without reopening.
- R9: Deselecting starts a precharge of PRE_CYC cycles. An opening edge during precharge is ignored (no read, no write) and pulses timing_viol.
- R10: While supply_ok is low, no write is stored and the bus is not driven.
- R11: A write whose data changed fewer than SETUP_CYC sample cycles before its commit pulses timing_viol. A write with data held steady does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply good; low blocks all accesses |
| en_a_n | input | 1 | Active-low chip enable |
| en_b | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| hi_sel_n | input | 1 | Active-low upper byte select |
| lo_sel_n | input | 1 | Active-low lower byte select |
| bus_addr | input | ADDR_W | Word address, low COL_W bits are the column |
| bus_din | input | 2*LANE_W | Write data |
| bus_dout | output | 2*LANE_W | Read data, zero in undriven lanes |
| bus_drv | output | 2 | Per-lane drive enable, bit 1 upper |
| timing_viol | output | 1 | One-cycle pulse on precharge or setup violation |

## Verification
Two functions can land in the same cycle: storing write data and starting a precharge. This happens when a deselect ends a write. The bench provokes it by raising wr_n and en_a_n on the same sample edge. It then judges three things: the word was stored once with the right data, no violation pulsed, and a later read returns it. A second collision is provoked by re-selecting a few cycles into a precharge. Here the bench expects a violation pulse and an untouched array.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PAGE,
        ST_RDY,
        ST_WRITE,
        ST_PRECH
    } sbr_state_t;

    localparam int SBR_LANES = 2;

endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/sbr_setup_mon.sv
module sbr_setup_mon #(
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din_s,
    output logic [DATA_W-1:0] din_q,
    output logic              setup_short
);

    localparam int SC_W = $clog2(SETUP_CYC + 1);

    logic [SC_W-1:0] stable_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q      <= '0;
            stable_cnt <= SC_W'(SETUP_CYC);
        end else begin
            din_q <= din_s;
            if (din_s != din_q)
                stable_cnt <= '0;
            else if (stable_cnt < SC_W'(SETUP_CYC))
                stable_cnt <= stable_cnt + SC_W'(1);
        end
    end

    assign setup_short = (stable_cnt < SC_W'(SETUP_CYC));

    // R11: a data change always opens a short window on the next cycle
    a_r11_change_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        (din_s != din_q) |=> setup_short);

endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
    parameter int AW     = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    wen,
    input  logic [LANES-1:0]        lane_en,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [0:DEPTH-1];

        always_ff @(posedge clk) begin
            if (wen && lane_en[g])
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int ROW_W    = 6,
    parameter int COL_W    = 2,
    parameter int ACC_CYC  = 4,
    parameter int PAGE_CYC = 2,
    parameter int PRE_CYC  = 6,
    localparam int AW      = ROW_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_s,
    input  logic             en_a_n_s,
    input  logic             en_b_s,
    input  logic             wr_n_s,
    input  logic             out_en_n_s,
    input  logic             hi_n_s,
    input  logic             lo_n_s,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    input  logic             setup_short,
    output logic             mem_wen,
    output logic [1:0]       mem_lanes,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       drive,
    output logic             viol
);

    localparam int MAX_A = (ACC_CYC > PAGE_CYC) ? ACC_CYC : PAGE_CYC;
    localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRE_CYC - 1);

    sbr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             sel_q, wr_n_q, hi_n_q, lo_n_q;
    logic             viol_q;

    logic sel_s, start_edge, sel_fall, wr_rise;
    logic row_chg, col_chg, cnt_done;
    logic commit, prech_hit;

    assign sel_s      = ~en_a_n_s & en_b_s;
    assign start_edge = sel_s & ~sel_q;
    assign sel_fall   = ~sel_s & sel_q;
    assign wr_rise    = wr_n_s & ~wr_n_q;
    assign row_chg    = (row_in != row_q);
    assign col_chg    = (col_in != col_q);
    assign cnt_done   = (cnt_q == '0);

    // state register and latched access fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
            col_q   <= '0;
            sel_q   <= 1'b0;
            wr_n_q  <= 1'b1;
            hi_n_q  <= 1'b1;
            lo_n_q  <= 1'b1;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            row_q   <= row_d;
            col_q   <= col_d;
            sel_q   <= sel_s;
            wr_n_q  <= wr_n_s;
            hi_n_q  <= hi_n_s;
            lo_n_q  <= lo_n_s;
            viol_q  <= prech_hit | (commit & setup_short);
        end
    end

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_done ? cnt_q : cnt_q - CNT_W'(1);
        row_d     = row_q;
        col_d     = col_q;
        commit    = 1'b0;
        prech_hit = 1'b0;
        if (!supply_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_edge) begin
                        row_d = row_in;
                        col_d = col_in;
                        if (!wr_n_s) begin
                            state_d = ST_WRITE;
                        end else begin
                            state_d = ST_READ;
                            cnt_d   = ACC_LD;
                        end
                    end else if (sel_fall) begin
                        state_d = ST_PRECH;
                        cnt_d   = PRE_LD;
                    end
                end
                ST_PRECH: begin
                    if (start_edge)
                        prech_hit = 1'b1;
                    else if (cnt_done)
                        state_d = ST_IDLE;
                end
                ST_READ, ST_PAGE: begin
                    if (sel_fall) begin
                        state_d = ST_PRECH;
                        cnt_d   = PRE_LD;
                    end else if (!wr_n_s) begin
                        state_d = ST_WRITE;
                        col_d   = col_in;
                    end else if (row_chg) begin
                        state_d = ST_READ;
                        row_d   = row_in;
                        col_d   = col_in;
                        cnt_d   = ACC_LD;
                    end else if (cnt_done) begin
                        state_d = ST_RDY;
                    end
                end
                ST_RDY: begin
                    if (sel_fall) begin
                        state_d = ST_PRECH;
                        cnt_d   = PRE_LD;
                    end else if (!wr_n_s) begin
                        state_d = ST_WRITE;
                        col_d   = col_in;
                    end else if (row_chg) begin
                        state_d = ST_READ;
                        row_d   = row_in;
                        col_d   = col_in;
                        cnt_d   = ACC_LD;
                    end else if (col_chg) begin
                        state_d = ST_PAGE;
                        col_d   = col_in;
                        cnt_d   = PAGE_LD;
                    end
                end
                ST_WRITE: begin
                    if (sel_fall) begin
                        commit  = 1'b1;
                        state_d = ST_PRECH;
                        cnt_d   = PRE_LD;
                    end else if (wr_rise) begin
                        commit  = 1'b1;
                        state_d = ST_RDY;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_wen   = commit;
        mem_lanes = {~hi_n_q, ~lo_n_q};
        mem_addr  = {row_q, col_q};
        viol      = viol_q;
        if (state_q == ST_RDY && supply_s && wr_n_s && !out_en_n_s)
            drive = {~hi_n_s, ~lo_n_s};
        else
            drive = 2'b00;
    end

    a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> (drive == 2'b00));

    a_r4_strobe_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_s |-> (drive == 2'b00));

    a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    a_r9_prech_ignores_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECH && start_edge) |=>
            (state_q != ST_READ && state_q != ST_WRITE));

    a_r10_supply_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_s |-> (!commit && drive == 2'b00));

endmodule

// File: rtl/sram_bus_responder.sv
module sram_bus_responder
    import sbr_pkg::*;
#(
    parameter int  ADDR_W    = 8,
    parameter int  COL_W     = 2,
    parameter int  LANE_W    = 8,
    parameter int  ACC_CYC   = 4,
    parameter int  PAGE_CYC  = 2,
    parameter int  PRE_CYC   = 6,
    parameter int  SETUP_CYC = 3,
    localparam int DATA_W    = SBR_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic              hi_sel_n,
    input  logic              lo_sel_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic [1:0]        bus_drv,
    output logic              timing_viol
);

    localparam int ROW_W = ADDR_W - COL_W;
    localparam int CTL_W = 7;

    logic [CTL_W-1:0]  ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s, din_q;
    logic              setup_short;
    logic              mem_wen;
    logic [1:0]        mem_lanes;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic [1:0]        drive;

    sbr_sync #(.W(CTL_W), .RST_VAL(7'b0101111)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({supply_ok, en_a_n, en_b, wr_n, out_en_n, hi_sel_n, lo_sel_n}),
        .q     (ctl_s)
    );

    sbr_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_addr),
        .q     (addr_s)
    );

    sbr_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_din),
        .q     (din_s)
    );

    sbr_setup_mon #(.DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)) u_setup (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_s       (din_s),
        .din_q       (din_q),
        .setup_short (setup_short)
    );

    sbr_ctrl #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .ACC_CYC  (ACC_CYC),
        .PAGE_CYC (PAGE_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_s    (ctl_s[6]),
        .en_a_n_s    (ctl_s[5]),
        .en_b_s      (ctl_s[4]),
        .wr_n_s      (ctl_s[3]),
        .out_en_n_s  (ctl_s[2]),
        .hi_n_s      (ctl_s[1]),
        .lo_n_s      (ctl_s[0]),
        .row_in      (addr_s[ADDR_W-1:COL_W]),
        .col_in      (addr_s[COL_W-1:0]),
        .setup_short (setup_short),
        .mem_wen     (mem_wen),
        .mem_lanes   (mem_lanes),
        .mem_addr    (mem_addr),
        .drive       (drive),
        .viol        (timing_viol)
    );

    sbr_array #(.AW(ADDR_W), .LANE_W(LANE_W), .LANES(SBR_LANES)) u_array (
        .clk     (clk),
        .wen     (mem_wen),
        .lane_en (mem_lanes),
        .addr    (mem_addr),
        .wdata   (din_q),
        .rdata   (mem_rdata)
    );

    for (genvar g = 0; g < SBR_LANES; g++) begin : g_out
        assign bus_dout[g*LANE_W +: LANE_W] = drive[g] ? mem_rdata[g*LANE_W +: LANE_W] : '0;
    end

    assign bus_drv = drive;

endmodule

// File: tb/sram_bus_responder_bench.sv
module sram_bus_responder_bench;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    logic        rst_n, supply_ok, en_a_n, en_b, wr_n, out_en_n, hi_sel_n, lo_sel_n;
    logic [7:0]  bus_addr;
    logic [15:0] bus_din, bus_dout;
    logic [1:0]  bus_drv;
    logic        timing_viol;

    int n_chk = 0;
    int n_bad = 0;
    int viol_cnt = 0;
    bit finished = 1'b0;
    logic [15:0] shadow [0:255];

    sram_bus_responder u_sram_bus_responder (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_a_n(en_a_n), .en_b(en_b),
        .wr_n(wr_n), .out_en_n(out_en_n), .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_drv(bus_drv),
        .timing_viol(timing_viol)
    );

    always @(posedge clk) if (timing_viol) viol_cnt <= viol_cnt + 1;

    // op[27:26]: 0 write ended by en_a_n, 1 strobe-ended write, 2 write framed by en_b, 3 read
    // sel[25:24] = {hi_sel_n, lo_sel_n}, addr[23:16], data[15:0]
    localparam logic [27:0] VEC [0:10] = '{
        {2'd0, 2'b00, 8'h10, 16'h1234},
        {2'd1, 2'b00, 8'h25, 16'hBEEF},
        {2'd2, 2'b00, 8'h3A, 16'hCAFE},
        {2'd3, 2'b00, 8'h10, 16'h0000},
        {2'd3, 2'b00, 8'h25, 16'h0000},
        {2'd3, 2'b00, 8'h3A, 16'h0000},
        {2'd1, 2'b10, 8'h10, 16'hAAAA},
        {2'd0, 2'b01, 8'h25, 16'h5555},
        {2'd3, 2'b00, 8'h10, 16'h0000},
        {2'd3, 2'b01, 8'h25, 16'h0000},
        {2'd3, 2'b10, 8'h3A, 16'h0000}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sel);
        if (supply_ok) begin
            if (!sel[1]) shadow[a][15:8] = d[15:8];
            if (!sel[0]) shadow[a][7:0]  = d[7:0];
        end
    endtask

    task automatic check_word(input logic [1:0] exp_drv, input logic [15:0] exp_d, input string tag);
        check(bus_drv == exp_drv, tag, {30'd0, bus_drv}, {30'd0, exp_drv});
        if (exp_drv[1]) check(bus_dout[15:8] == exp_d[15:8], tag, {24'd0, bus_dout[15:8]}, {24'd0, exp_d[15:8]});
        if (exp_drv[0]) check(bus_dout[7:0] == exp_d[7:0], tag, {24'd0, bus_dout[7:0]}, {24'd0, exp_d[7:0]});
    endtask

    task automatic ce_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sel);
        bus_addr = a; bus_din = d; {hi_sel_n, lo_sel_n} = sel; wr_n = 1'b0;
        tick(2); en_a_n = 1'b0;
        tick(12); en_a_n = 1'b1;
        tick(3); wr_n = 1'b1; {hi_sel_n, lo_sel_n} = 2'b00;
        tick(12);
        model_write(a, d, sel);
    endtask

    task automatic enb_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sel);
        en_b = 1'b0; tick(2);
        en_a_n = 1'b0; bus_addr = a; bus_din = d; {hi_sel_n, lo_sel_n} = sel; wr_n = 1'b0;
        tick(2); en_b = 1'b1;
        tick(12); en_b = 1'b0;
        tick(3); wr_n = 1'b1; en_a_n = 1'b1;
        tick(1); en_b = 1'b1; {hi_sel_n, lo_sel_n} = 2'b00;
        tick(12);
        model_write(a, d, sel);
    endtask

    task automatic we_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sel,
                            input bit late, input bit together);
        bus_addr = a; {hi_sel_n, lo_sel_n} = sel; en_a_n = 1'b0;
        tick(12);
        bus_din = late ? ~d : d; wr_n = 1'b0;
        tick(10);
        if (late) bus_din = d;
        tick(1);
        if (together) begin
            wr_n = 1'b1; en_a_n = 1'b1;
        end else begin
            wr_n = 1'b1; tick(4); en_a_n = 1'b1;
        end
        tick(12);
        {hi_sel_n, lo_sel_n} = 2'b00;
        model_write(a, d, sel);
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sel, input bit on, input string tag);
        bus_addr = a; {hi_sel_n, lo_sel_n} = sel; out_en_n = 1'b0; en_a_n = 1'b0;
        tick(12);
        check_word(on ? ~sel : 2'b00, shadow[a], tag);
        en_a_n = 1'b1; out_en_n = 1'b1; {hi_sel_n, lo_sel_n} = 2'b00;
        tick(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v0;
        rst_n = 1'b0; supply_ok = 1'b1; en_a_n = 1'b1; en_b = 1'b1; wr_n = 1'b1;
        out_en_n = 1'b1; hi_sel_n = 1'b0; lo_sel_n = 1'b0; bus_addr = '0; bus_din = '0;
        tick(4); rst_n = 1'b1; tick(3);

        // R1 reset state
        check(bus_drv == 2'b00, "R1 drv", {30'd0, bus_drv}, 0);
        check(bus_dout == 16'h0, "R1 dout", {16'd0, bus_dout}, 0);
        check(timing_viol == 1'b0, "R1 viol", {31'd0, timing_viol}, 0);
        tick(10);

        // table walk: R2 (both enable edges), R5 (all three commit events, lane masks), R6
        for (int i = 0; i < 11; i++) begin
            logic [27:0] v;
            v = VEC[i];
            case (v[27:26])
                2'd0: ce_write(v[23:16], v[15:0], v[25:24]);
                2'd1: we_write(v[23:16], v[15:0], v[25:24], 1'b0, 1'b0);
                2'd2: enb_write(v[23:16], v[15:0], v[25:24]);
                default: rd(v[23:16], v[25:24], 1'b1, "R2_R5_R6 table read");
            endcase
        end
        check(viol_cnt == 0, "R11 clean writes no viol", viol_cnt, 0);

        // R7 latency gating, R6 output enable and lane gating, R4 write switch and page write
        ce_write(8'h40, 16'h0F0F, 2'b00);
        bus_addr = 8'h40; out_en_n = 1'b0; en_a_n = 1'b0;
        tick(2); check(bus_drv == 2'b00, "R7 early", {30'd0, bus_drv}, 0);
        tick(3); check(bus_drv == 2'b00, "R7 in access", {30'd0, bus_drv}, 0);
        tick(6); check_word(2'b11, 16'h0F0F, "R7 valid");
        out_en_n = 1'b1; tick(3); check(bus_drv == 2'b00, "R6 oe high", {30'd0, bus_drv}, 0);
        out_en_n = 1'b0; tick(3); check(bus_drv == 2'b11, "R6 oe low", {30'd0, bus_drv}, 3);
        hi_sel_n = 1'b1; tick(3); check_word(2'b01, 16'h0F0F, "R6 lower only");
        hi_sel_n = 1'b0;
        bus_din = 16'h7777; wr_n = 1'b0;
        tick(3); check(bus_drv == 2'b00, "R4 release", {30'd0, bus_drv}, 0);
        tick(6); wr_n = 1'b1; tick(6);
        shadow[8'h40] = 16'h7777;
        check_word(2'b11, 16'h7777, "R4 R5 write then readback");
        bus_addr = 8'h41; tick(6);
        bus_din = 16'h8888; wr_n = 1'b0; tick(8); wr_n = 1'b1; tick(6);
        shadow[8'h41] = 16'h8888;
        check_word(2'b11, 16'h8888, "R4 page write");
        en_a_n = 1'b1; out_en_n = 1'b1; tick(12);
        rd(8'h40, 2'b00, 1'b1, "R4 first column kept");
        rd(8'h41, 2'b00, 1'b1, "R4 second column");

        // R8 page read and row change while selected
        ce_write(8'h42, 16'h4242, 2'b00);
        ce_write(8'h43, 16'h4343, 2'b00);
        ce_write(8'h80, 16'h8080, 2'b00);
        bus_addr = 8'h42; out_en_n = 1'b0; en_a_n = 1'b0;
        tick(12); check_word(2'b11, 16'h4242, "R8 open");
        bus_addr = 8'h43; tick(8); check_word(2'b11, 16'h4343, "R8 column change");
        bus_addr = 8'h80; tick(3); check(bus_drv == 2'b00, "R8 row reopen", {30'd0, bus_drv}, 0);
        tick(9); check_word(2'b11, 16'h8080, "R8 row change");
        en_a_n = 1'b1; out_en_n = 1'b1; tick(12);

        // R3 write from open: never driven although output enable is low
        begin
            bit seen = 1'b0;
            out_en_n = 1'b0; wr_n = 1'b0; bus_addr = 8'h50; bus_din = 16'h5050;
            tick(2); en_a_n = 1'b0;
            for (int k = 0; k < 12; k++) begin tick(1); if (bus_drv != 2'b00) seen = 1'b1; end
            en_a_n = 1'b1; tick(3); wr_n = 1'b1; out_en_n = 1'b1; tick(12);
            check(!seen, "R3 bus quiet in write", {31'd0, seen}, 0);
            shadow[8'h50] = 16'h5050;
            rd(8'h50, 2'b00, 1'b1, "R3 stored");
        end

        // R9 reopen during precharge is ignored and flagged
        v0 = viol_cnt;
        bus_addr = 8'h10; en_a_n = 1'b0; tick(12);
        en_a_n = 1'b1; tick(2);
        wr_n = 1'b0; bus_din = 16'hDEAD; en_a_n = 1'b0; tick(12);
        en_a_n = 1'b1; tick(3); wr_n = 1'b1; tick(12);
        check(viol_cnt == v0 + 1, "R9 viol pulse", viol_cnt - v0, 1);
        rd(8'h10, 2'b00, 1'b1, "R9 array untouched");

        // R10 supply low blocks writes and reads
        supply_ok = 1'b0; tick(4);
        ce_write(8'h10, 16'hFFFF, 2'b00);
        rd(8'h10, 2'b00, 1'b0, "R10 no drive");
        supply_ok = 1'b1; tick(4);
        rd(8'h10, 2'b00, 1'b1, "R10 write blocked");

        // R11 late data change flagged
        v0 = viol_cnt;
        we_write(8'h70, 16'h1357, 2'b00, 1'b1, 1'b0);
        check(viol_cnt == v0 + 1, "R11 setup viol", viol_cnt - v0, 1);

        // coincident commit and precharge start (R5)
        v0 = viol_cnt;
        we_write(8'h60, 16'h6060, 2'b00, 1'b0, 1'b1);
        check(viol_cnt == v0, "R5 coincident no viol", viol_cnt - v0, 0);
        rd(8'h60, 2'b00, 1'b1, "R5 coincident commit");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule